// File: doc/BRIEF.md
# Significance-Sliced Burst Packer

This block sits between a cache-line interface and a 64-bit memory rank built from sixteen ×4 devices. On the write side it takes a full 64-byte line of sixteen 32-bit floating-point words and sends it as an 8-beat burst. Each device lane carries the same 2-bit significance slice of the two words in the current beat. Because of this mapping, the sign and exponent bits of every word stay within a fixed group of devices. That group can be refreshed at the normal rate, while the lanes that hold only low mantissa bits can be refreshed more slowly.

On the read side the block collects an 8-beat burst and reverses the slicing to rebuild the sixteen words. It presents the rebuilt line with a single-cycle valid strobe. The write path supports backpressure on the beat output. A line offered during a burst waits until the last beat of that burst has been taken.

Top module: `sigslice_packer`

## Requirements
- R1: After reset, beatOutValid and lineOutValid are low and lineInReady is high.
- R2: Word i of a line occupies bits [32i+31:32i]. In beat k, nibble n (bits [4n+3:4n]) equals {word(2k+1)[2n+1:2n], word(2k)[2n+1:2n]}, so the odd word's pair is in the upper half.
- R3: An accepted line is sent as exactly 8 beats with k ascending from 0. A beat advances only on a cycle where beatOutValid and beatOutReady are both high.
- R4: beatOutLast is high on the eighth beat of a burst and on no other beat.
- R5: While beatOutValid is high and beatOutReady is low, beatOutValid and beatOutData hold their values on the next cycle.
- R6: lineInReady is low for the whole of a burst. A line offered during a burst is not taken, and the beats of the current burst are unaffected.
- R7: For words that have only bits [31:23] set (sign and exponent), every beat has bits [43:0] at zero. Those bits reach only nibbles 11 to 15.
- R8: Read beats are stored in arrival order, counting from 0 after reset or after the previous beat flagged last. Nibble n of read beat k is split back using the same mapping as R2. A cycle with beatInValid low stores nothing and does not advance the count.
- R9: On the cycle after a read beat with beatInLast high, lineOutValid is high for exactly one cycle and lineOutData holds the rebuilt line.
- R10: lineInReady is high again on the cycle after the eighth beat is accepted, so back-to-back lines lose no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineInValid | input | 1 | Write line offered |
| lineInReady | output | 1 | Write line can be accepted |
| lineInData | input | 512 | Write line, 16 words |
| beatOutValid | output | 1 | Write beat valid |
| beatOutReady | input | 1 | Write beat taken by the rank side |
| beatOutData | output | 64 | Write beat, 16 device nibbles |
| beatOutLast | output | 1 | Final beat of the write burst |
| beatInValid | input | 1 | Read beat valid |
| beatInData | input | 64 | Read beat, 16 device nibbles |
| beatInLast | input | 1 | Final beat of the read burst |
| lineOutValid | output | 1 | Rebuilt line valid, one-cycle strobe |
| lineOutData | output | 512 | Rebuilt read line |

## Verification
Random lines exercise every bit position, so a swapped odd/even half, a misplaced pair or a wrong word order shows up in the per-beat comparison against a bench packing function. Random ready patterns separate correct holding under backpressure from beat skipping or repetition. A line of words with only sign and exponent bits set shows whether the critical bits stay in the top five lanes. A second line held on the input during a burst, and read bursts with idle gaps, show whether stalls and gaps are respected. A loopback of random lines through the read path confirms that the unslicing exactly inverts the packing.

// File: rtl/sigslice_pkg.sv
package sigslice_pkg;
  parameter int BEAT_IDX_W = 3;

  typedef struct packed {
    logic                  loadLine;
    logic [BEAT_IDX_W-1:0] wrBeat;
    logic                  capBeat;
    logic [BEAT_IDX_W-1:0] rdBeat;
  } ctrlStrobe_t;
endpackage

// File: rtl/sigslice_ctrl.sv
module sigslice_ctrl
  import sigslice_pkg::*;
#(
  parameter int BEATS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineInValid,
  output logic        lineInReady,
  output logic        beatOutValid,
  input  logic        beatOutReady,
  output logic        beatOutLast,
  input  logic        beatInValid,
  input  logic        beatInLast,
  output logic        lineOutValid,
  output ctrlStrobe_t strb
);
  localparam logic [BEAT_IDX_W-1:0] LAST_IDX = BEAT_IDX_W'(BEATS - 1);

  logic                  busy;
  logic [BEAT_IDX_W-1:0] wrCnt;
  logic [BEAT_IDX_W-1:0] rdCnt;

  assign lineInReady  = !busy;
  assign beatOutValid = busy;
  assign beatOutLast  = busy && (wrCnt == LAST_IDX);

  always_comb begin
    strb.loadLine = lineInValid && !busy;
    strb.wrBeat   = wrCnt;
    strb.capBeat  = beatInValid;
    strb.rdBeat   = rdCnt;
  end

  // write burst sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      wrCnt <= '0;
    end else if (strb.loadLine) begin
      busy  <= 1'b1;
      wrCnt <= '0;
    end else if (busy && beatOutReady) begin
      if (wrCnt == LAST_IDX) begin
        busy  <= 1'b0;
        wrCnt <= '0;
      end else begin
        wrCnt <= wrCnt + 1'b1;
      end
    end
  end

  // read burst collection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCnt        <= '0;
      lineOutValid <= 1'b0;
    end else begin
      lineOutValid <= beatInValid && beatInLast;
      if (beatInValid) begin
        rdCnt <= beatInLast ? '0 : rdCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sigslice_datapath.sv
module sigslice_datapath
  import sigslice_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int WORDS   = 16,
  parameter int SLICE_W = 2
) (
  input  logic                      clk,
  input  ctrlStrobe_t               strb,
  input  logic [WORDS*WORD_W-1:0]   lineInData,
  output logic [2*WORD_W-1:0]       beatOutData,
  input  logic [2*WORD_W-1:0]       beatInData,
  output logic [WORDS*WORD_W-1:0]   lineOutData
);
  localparam int DEVS  = WORD_W / SLICE_W;
  localparam int NIB_W = 2 * SLICE_W;

  logic [WORD_W-1:0] lineQ [WORDS];
  logic [WORD_W-1:0] asmQ  [WORDS];
  logic [WORD_W-1:0] evenW, oddW, rdEven, rdOdd;

  assign evenW = lineQ[{strb.wrBeat, 1'b0}];
  assign oddW  = lineQ[{strb.wrBeat, 1'b1}];

  for (genvar n = 0; n < DEVS; n++) begin : g_dev
    assign beatOutData[n*NIB_W +: NIB_W] =
      {oddW[n*SLICE_W +: SLICE_W], evenW[n*SLICE_W +: SLICE_W]};
    assign rdEven[n*SLICE_W +: SLICE_W] = beatInData[n*NIB_W +: SLICE_W];
    assign rdOdd[n*SLICE_W +: SLICE_W]  = beatInData[n*NIB_W+SLICE_W +: SLICE_W];
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign lineOutData[i*WORD_W +: WORD_W] = asmQ[i];
  end

  always_ff @(posedge clk) begin
    if (strb.loadLine) begin
      for (int i = 0; i < WORDS; i++) lineQ[i] <= lineInData[i*WORD_W +: WORD_W];
    end
    if (strb.capBeat) begin
      asmQ[{strb.rdBeat, 1'b0}] <= rdEven;
      asmQ[{strb.rdBeat, 1'b1}] <= rdOdd;
    end
  end
endmodule

// File: rtl/sigslice_packer.sv
module sigslice_packer
  import sigslice_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int WORDS   = 16,
  parameter int SLICE_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lineInValid,
  output logic                    lineInReady,
  input  logic [WORDS*WORD_W-1:0] lineInData,
  output logic                    beatOutValid,
  input  logic                    beatOutReady,
  output logic [2*WORD_W-1:0]     beatOutData,
  output logic                    beatOutLast,
  input  logic                    beatInValid,
  input  logic [2*WORD_W-1:0]     beatInData,
  input  logic                    beatInLast,
  output logic                    lineOutValid,
  output logic [WORDS*WORD_W-1:0] lineOutData
);
  localparam int BEATS = WORDS / 2;

  ctrlStrobe_t strb;

  sigslice_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lineInValid(lineInValid), .lineInReady(lineInReady),
    .beatOutValid(beatOutValid), .beatOutReady(beatOutReady),
    .beatOutLast(beatOutLast),
    .beatInValid(beatInValid), .beatInLast(beatInLast),
    .lineOutValid(lineOutValid), .strb(strb)
  );

  sigslice_datapath #(.WORD_W(WORD_W), .WORDS(WORDS), .SLICE_W(SLICE_W)) u_dp (
    .clk(clk), .strb(strb),
    .lineInData(lineInData), .beatOutData(beatOutData),
    .beatInData(beatInData), .lineOutData(lineOutData)
  );
endmodule

// File: rtl/sigslice_packer_chk.sv
module sigslice_packer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        lineInValid,
  input logic        lineInReady,
  input logic        beatOutValid,
  input logic        beatOutReady,
  input logic [63:0] beatOutData,
  input logic        beatOutLast,
  input logic        beatInValid,
  input logic        beatInLast,
  input logic        lineOutValid
);
  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOutValid && !beatOutReady |=> beatOutValid && $stable(beatOutData));

  // R4
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOutLast |-> beatOutValid);

  // R10
  ready_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatOutValid && beatOutReady && beatOutLast |=> lineInReady && !beatOutValid);

  // R6
  burst_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineInValid && lineInReady |=> beatOutValid && !lineInReady);

  // R9
  line_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineOutValid |-> $past(beatInValid && beatInLast));
endmodule

bind sigslice_packer sigslice_packer_chk u_chk (
  .clk(clk), .rstN(rstN),
  .lineInValid(lineInValid), .lineInReady(lineInReady),
  .beatOutValid(beatOutValid), .beatOutReady(beatOutReady),
  .beatOutData(beatOutData), .beatOutLast(beatOutLast),
  .beatInValid(beatInValid), .beatInLast(beatInLast),
  .lineOutValid(lineOutValid)
);

// File: tb/sigslice_packer_tb.sv
module sigslice_packer_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         lineInValid = 1'b0;
  logic         lineInReady;
  logic [511:0] lineInData = '0;
  logic         beatOutValid;
  logic         beatOutReady = 1'b0;
  logic [63:0]  beatOutData;
  logic         beatOutLast;
  logic         beatInValid = 1'b0;
  logic [63:0]  beatInData = '0;
  logic         beatInLast = 1'b0;
  logic         lineOutValid;
  logic [511:0] lineOutData;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  sigslice_packer u_dut (
    .clk(clk), .rstN(rstN),
    .lineInValid(lineInValid), .lineInReady(lineInReady), .lineInData(lineInData),
    .beatOutValid(beatOutValid), .beatOutReady(beatOutReady),
    .beatOutData(beatOutData), .beatOutLast(beatOutLast),
    .beatInValid(beatInValid), .beatInData(beatInData), .beatInLast(beatInLast),
    .lineOutValid(lineOutValid), .lineOutData(lineOutData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] packBeat(input logic [511:0] line, input int k);
    logic [31:0] ev, od;
    logic [63:0] b;
    ev = line[64*k +: 32];
    od = line[64*k+32 +: 32];
    for (int n = 0; n < 16; n++) b[4*n +: 4] = {od[2*n +: 2], ev[2*n +: 2]};
    return b;
  endfunction

  function automatic logic [511:0] randLine();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[32*i +: 32] = $urandom;
    return l;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acceptLine(input logic [511:0] line);
    @(negedge clk);
    lineInValid = 1'b1;
    lineInData  = line;
    while (!lineInReady) @(negedge clk);
    @(posedge clk);
    #1 lineInValid = 1'b0;
  endtask

  // collect one burst with random backpressure; optionally offer a second line meanwhile
  task automatic collectBurst(input logic [511:0] line, input int readyPct,
                              input bit offerNext, input logic [511:0] nextLine);
    int k = 0;
    int mism = 0;
    logic [63:0] heldData;
    bit stalled = 0;
    while (k < 8) begin
      @(negedge clk);
      if (offerNext) begin
        lineInValid = 1'b1;
        lineInData  = nextLine;
        if (lineInReady) mism++;
      end
      if (stalled && beatOutData !== heldData) mism++; // R5
      beatOutReady = (($urandom % 100) < readyPct);
      if (!beatOutValid) mism++;
      if (beatOutData !== packBeat(line, k)) begin
        $display("FAIL R2/R3 beat %0d actual=%h expected=%h", k, beatOutData, packBeat(line, k));
        bad++;
      end
      if (beatOutLast !== (k == 7)) begin
        $display("FAIL R4 beat %0d last actual=%b expected=%b", k, beatOutLast, (k == 7));
        bad++;
      end
      total += 2;
      stalled = !beatOutReady;
      heldData = beatOutData;
      if (beatOutReady) k++;
    end
    check("R5/R6 stall behaviour", 512'(mism), 512'(0));
    @(negedge clk);
    beatOutReady = 1'b0;
    check("R10 ready after last", 512'(lineInReady), 512'(1));
    if (!offerNext) check("R3 no extra beat", 512'(beatOutValid), 512'(0));
  endtask

  task automatic sendRead(input logic [511:0] line, input int gapPct);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      while (($urandom % 100) < gapPct) begin
        beatInValid = 1'b0;
        beatInData  = $urandom; // R8: ignored while invalid
        beatInLast  = 1'b1;
        @(negedge clk);
        check("R9 no strobe mid-burst", 512'(lineOutValid), 512'(0));
      end
      beatInValid = 1'b1;
      beatInData  = packBeat(line, k);
      beatInLast  = (k == 7);
    end
    @(negedge clk);
    beatInValid = 1'b0;
    beatInLast  = 1'b0;
    check("R9 line strobe", 512'(lineOutValid), 512'(1));
    check("R8 rebuilt line", lineOutData, line);
    @(negedge clk);
    check("R9 strobe one cycle", 512'(lineOutValid), 512'(0));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [511:0] a, b, crit;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 beatOutValid", 512'(beatOutValid), 512'(0));
    check("R1 lineOutValid", 512'(lineOutValid), 512'(0));
    check("R1 lineInReady", 512'(lineInReady), 512'(1));

    // R2/R3: full-rate then random backpressure
    a = randLine();
    acceptLine(a);
    collectBurst(a, 100, 0, '0);
    for (int t = 0; t < 6; t++) begin
      a = randLine();
      acceptLine(a);
      collectBurst(a, 40, 0, '0);
    end

    // R7: only sign and exponent bits set
    crit = '0;
    for (int i = 0; i < 16; i++) crit[32*i +: 32] = 32'hFF80_0000 & $urandom | (i[0] ? 32'h8000_0000 : 32'h0080_0000);
    acceptLine(crit);
    begin
      int k = 0;
      int leak = 0;
      beatOutReady = 1'b1;
      while (k < 8) begin
        @(negedge clk);
        if (beatOutData[43:0] !== '0) leak++;
        if (beatOutData !== packBeat(crit, k)) leak++;
        k++;
      end
      @(negedge clk);
      beatOutReady = 1'b0;
      check("R7 critical bits confined", 512'(leak), 512'(0));
    end

    // R6/R10: second line offered during a burst
    a = randLine();
    b = randLine();
    acceptLine(a);
    collectBurst(a, 60, 1, b);
    @(posedge clk);
    #1 lineInValid = 1'b0;
    collectBurst(b, 70, 0, '0);

    // R8/R9: read path with and without gaps, then walking ones
    for (int t = 0; t < 6; t++) sendRead(randLine(), (t < 2) ? 0 : 30);
    for (int w = 0; w < 4; w++) begin
      a = '0;
      a[w*131 % 512] = 1'b1;
      sendRead(a, 0);
    end

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule